// File: doc/BRIEF.md
# Lane Bit-Plane Transposer

This block collects one LED's worth of colour bytes for several parallel output lanes and turns them into a stream of 32-bit lane words. Each lane word carries one bit from every lane. A parallel serial-LED driver can then write each word straight to a wide output port. In that port, each lane owns one bit position.

Every incoming byte is scaled by an 8-bit brightness value as it is accepted. When a word is built, the stored bits are inverted, so a set bit means "drop this lane low early", which encodes a zero bit. Lanes are not packed into adjacent bits. Lane 0 sits at bit 0. Each later lane takes the next higher bit that is set in a 32-bit port mask parameter, so port bits outside the mask are skipped.

The colour byte that a lane contributes to a group is picked through a three-entry colour order parameter. That pick advances by one entry from each lane to the next. The byte stream arrives lane-major through a valid/ready handshake: lane 0 bytes 0, 1, 2, then lane 1, and so on. Once every byte of the LED has arrived, 24 words leave on consecutive cycles. The lane count must not exceed the number of set bits in the port mask.

Top module: `lane_plane_xpose`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) discards any partially received LED. The block then shows `in_ready`=1 and `out_valid`=0, and the next accepted byte is taken as lane 0 byte 0.
- R2: Each accepted byte b is stored as (b*scale)>>8, using the `scale` value present in the cycle of acceptance. A lane's bit in a word is the inverse of the corresponding bit of that stored value.
- R3: Within a colour group, word j (j = 0..7) carries bit 7-j of the selected byte of each lane, so the most significant bit comes first.
- R4: Lane 0 occupies word bit 0. Lane n (n ≥ 1) occupies the n-th set bit of PORT_MASK above bit 0, counting upward.
- R5: Every word bit that holds no lane is 0, and `out_word` is all zero while `out_valid` is low.
- R6: Input bytes arrive lane-major, with stored byte indices 0, 1, 2 per lane. COLOR_ORDER packs three 2-bit entries, entry e at bits [2e+1:2e]. In group g (0..2), lane l contributes its stored byte with index entry[(g+l) mod 3].
- R7: While collecting, `in_ready` is 1 and a byte is taken on each edge with `in_valid` high. After 3*LANES bytes, `in_ready` is 0 and input is ignored until emission ends.
- R8: After the last byte is accepted, `out_valid` is high for exactly 24 consecutive cycles, one word per cycle. Groups come in the order g=0,1,2, and the block then returns to collecting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| scale | input | 8 | Brightness factor applied to each accepted byte |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block is collecting bytes |
| in_data | input | 8 | Colour byte |
| out_valid | output | 1 | `out_word` carries a lane word |
| out_word | output | 32 | Lane word, one bit per lane position |

## Verification
The bench builds the block with twelve lanes, the default port mask 0x77EFF3FE and a rotated colour order of (2, 0, 1). Twelve lanes run past bits 10 and 11, which the mask excludes, so lanes 10 and 11 must land on bits 12 and 13. Bit 0 is outside the mask yet still carries lane 0. Because twelve is a multiple of three and the order is not the identity, every order entry is used in every group, and a wrong rotation or a wrong stored-index mapping changes the output.

// File: rtl/lane_plane_xpose.sv
module lane_plane_xpose #(
  parameter int          LANES       = 4,
  parameter logic [31:0] PORT_MASK   = 32'h77EFF3FE,
  parameter logic [5:0]  COLOR_ORDER = 6'b10_01_00
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  scale,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  output logic        out_valid,
  output logic [31:0] out_word
);

  localparam int NBYTES = 3 * LANES;
  localparam int NWORDS = 24;
  localparam int CW     = $clog2(NBYTES > NWORDS ? NBYTES : NWORDS);
  localparam logic [CW-1:0] LAST_BYTE = CW'(NBYTES - 1);
  localparam logic [CW-1:0] LAST_WORD = CW'(NWORDS - 1);

  function automatic int lane_pos(input int l);
    int p;
    int n;
    p = 0;
    n = 0;
    for (int i = 1; i < 32; i++) begin
      if (PORT_MASK[i] && n < l) begin
        p = i;
        n++;
      end
    end
    return p;
  endfunction

  function automatic logic [31:0] used_bits();
    logic [31:0] r;
    r = '0;
    for (int l = 0; l < LANES; l++) r[lane_pos(l)] = 1'b1;
    return r;
  endfunction

  localparam logic [31:0] USED = used_bits();

  logic          busy;
  logic [CW-1:0] cnt;
  logic [7:0]    mem [NBYTES];
  logic [15:0]   prod;
  logic [1:0]    grp;
  logic [2:0]    bitsel;
  logic [LANES-1:0] lane_bit;

  assign prod      = {8'b0, in_data} * {8'b0, scale};
  assign in_ready  = !busy;
  assign out_valid = busy;
  assign grp       = cnt[4:3];
  assign bitsel    = ~cnt[2:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      for (int i = 0; i < NBYTES; i++) mem[i] <= '0;
    end else if (!busy) begin
      if (in_valid) begin
        mem[cnt] <= prod[15:8];
        if (cnt == LAST_BYTE) begin
          cnt  <= '0;
          busy <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end else begin
      if (cnt == LAST_WORD) begin
        cnt  <= '0;
        busy <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic [2:0] ROT = 3'(l % 3);
    logic [2:0] sum;
    logic [1:0] sel;
    logic [1:0] ent;
    logic [7:0] val;
    assign sum = {1'b0, grp} + ROT;
    assign sel = (sum >= 3'd3) ? 2'(sum - 3'd3) : sum[1:0];
    assign ent = COLOR_ORDER[{sel, 1'b0} +: 2];
    assign val = mem[l * 3 + int'(ent)];
    assign lane_bit[l] = ~val[bitsel];
  end

  always_comb begin
    out_word = '0;
    if (busy) begin
      for (int l = 0; l < LANES; l++) out_word[lane_pos(l)] = lane_bit[l];
    end
  end

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_word & ~USED) == 32'b0);  // R5
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> out_word == 32'b0);  // R5
  AST_START_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_valid));  // R7
  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cnt != LAST_WORD) |=> out_valid);  // R8
  AST_RUN_ENDS: assert property (@(posedge clk) disable iff (rst)
    $fell(out_valid) |-> $past(cnt) == LAST_WORD);  // R8

endmodule

// File: tb/sim_lane_plane_xpose.sv
module sim_lane_plane_xpose;
  localparam int          LANES = 12;
  localparam int          NB    = 3 * LANES;
  localparam logic [31:0] MASK  = 32'h77EFF3FE;
  localparam logic [5:0]  ORDV  = 6'b01_00_10;
  localparam int          ORD [3] = '{2, 0, 1};
  localparam logic [15:0] VEC [6] = '{16'hFF_00, 16'h80_11, 16'h00_5A,
                                      16'hFF_37, 16'h40_C3, 16'hC8_01};

  logic clk = 0, rst = 1, in_valid = 0;
  logic [7:0] scale = 0, in_data = 0;
  logic in_ready, out_valid;
  logic [31:0] out_word;
  logic [7:0] bts [NB];
  int pos [LANES];
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  lane_plane_xpose #(.LANES(LANES), .PORT_MASK(MASK), .COLOR_ORDER(ORDV)) u0 (
    .clk(clk), .rst(rst), .scale(scale), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_word(out_word));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int w, input logic [7:0] sc);
    logic [31:0] r;
    logic [15:0] p;
    int g, k;
    r = '0;
    g = w / 8;
    k = 7 - (w % 8);
    for (int l = 0; l < LANES; l++) begin
      p = {8'b0, bts[l * 3 + ORD[(g + l) % 3]]} * {8'b0, sc};
      r[pos[l]] = ~p[8 + k];
    end
    return r;
  endfunction

  task automatic run_led(input logic [7:0] sc, input bit junk);
    logic [31:0] used;
    used = '0;
    for (int l = 0; l < LANES; l++) used[pos[l]] = 1'b1;
    scale = sc;
    for (int i = 0; i < NB; i++) begin
      in_valid = 1;
      in_data  = bts[i];
      @(posedge clk);
      @(negedge clk);
    end
    in_valid = junk;
    in_data  = 8'hAA;
    scale    = 8'h00;
    for (int w = 0; w < 24; w++) begin
      check(out_valid == 1'b1, "R8 out_valid run", {31'b0, out_valid}, 32'd1);
      check(out_word == exp_word(w, sc), "R2/R3/R4/R6 word", out_word, exp_word(w, sc));
      check((out_word & ~used) == 0, "R5 unused bits", out_word & ~used, 32'd0);
      if (w == 0) check(in_ready == 1'b0, "R7 ready low", {31'b0, in_ready}, 32'd0);
      @(negedge clk);
    end
    in_valid = 0;
    check(out_valid == 1'b0 && in_ready == 1'b1, "R8 run end", {30'b0, out_valid, in_ready}, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int p;
    p = 0;
    pos[0] = 0;
    for (int l = 1; l < LANES; l++) begin
      p++;
      while (!MASK[p]) p++;
      pos[l] = p;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    check(in_ready == 1 && out_valid == 0 && out_word == 0, "R1 reset state",
          {30'b0, in_ready, out_valid}, 32'd2);
    check(pos[10] == 12 && pos[11] == 13, "R4 skip gap", pos[10], 12);
    for (int v = 0; v < 6; v++) begin
      for (int i = 0; i < NB; i++)
        bts[i] = (VEC[v][7:0] == 0) ? 8'hFF : 8'((VEC[v][7:0] * (i + 1)) ^ (i * 29));
      run_led(VEC[v][15:8], v[0]);
    end
    // R1: partial LED discarded by reset
    for (int i = 0; i < 5; i++) begin
      in_valid = 1;
      in_data  = 8'h33;
      @(posedge clk);
      @(negedge clk);
    end
    in_valid = 0;
    rst = 1;
    @(negedge clk);
    rst = 0;
    check(in_ready == 1 && out_valid == 0, "R1 mid reset", {30'b0, in_ready, out_valid}, 32'd2);
    for (int i = 0; i < NB; i++) bts[i] = 8'(i * 7 + 1);
    run_led(8'hFF, 1'b1);
    // R7: idle with in_valid low takes nothing
    repeat (5) @(negedge clk);
    check(out_valid == 0, "R7 idle", {31'b0, out_valid}, 32'd0);
    for (int i = 0; i < NB; i++) bts[i] = 8'(255 - i * 5);
    run_led(8'h9C, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule